// File: doc/BRIEF.md
# Quadrature to Direction-Pulse Converter

This block lets a modern two-channel incremental rotary encoder stand in for an older rotary pulse switch. The old switch signals rotation on two separate lines, one per direction. Each line rests high and gives one fixed-width low pulse per detent. The encoder's two channels are pulled high, so the resting detent reads as both bits high. The block brings the channels into the clock domain and follows every Gray-code transition with a signed step counter. Each time a full detent of four transitions has built up, it issues one timed low pulse on the matching output line.

The counter is forced to zero whenever the encoder sits in the resting state. This puts the count back in step after a missed transition. The block keeps decoding while a pulse is being driven, and it holds at most one waiting pulse per direction. Waiting pulses go out in the order they arrived, with a guaranteed high interval between any two pulses. This gap gives the receiver a clean rising edge to act on.

Top module: `qenc_pulse_conv`

## Requirements
- R1: After synchronous active-high reset both outputs are high. The step counter is zero and the stored previous state is 3, so the first full detent from rest yields exactly one pulse.
- R2: The state is {enc_b, enc_a}, with bit 0 = A and bit 1 = B. The transitions 3→1, 1→0, 0→2 and 2→3 each add one step. Four added steps from rest drive exactly one low pulse on inc_pulse_n and none on dec_pulse_n.
- R3: The transitions 3→2, 2→0, 0→1 and 1→3 each remove one step. Four removed steps from rest drive exactly one low pulse on dec_pulse_n and none on inc_pulse_n.
- R4: A pulse is issued only when the count would pass +3 or -3, and the count then moves back toward zero by 4. A partial detent that is turned back to rest yields no pulse.
- R5: A transition that flips both bits at once (0↔3 or 1↔2) leaves the count unchanged, but it still becomes the stored previous state for the next transition.
- R6: Whenever the synchronised state is 3, the count is cleared to zero.
- R7: Every output pulse stays low for exactly PULSE_CYC clock cycles (default 128).
- R8: Between the end of one pulse and the start of the next, on either output, both lines stay high for at least GAP_CYC cycles.
- R9: The two outputs are never low at the same time.
- R10: A detent that completes while a pulse is in progress is kept as one waiting pulse for its direction. Further detents in the same direction are dropped while that pulse is still waiting.
- R11: When both directions have a waiting pulse, they are served in the order in which they were queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A, asynchronous, high at rest |
| enc_b | input | 1 | Encoder channel B, asynchronous, high at rest |
| inc_pulse_n | output | 1 | Active-low pulse, one per forward detent |
| dec_pulse_n | output | 1 | Active-low pulse, one per backward detent |

## Verification
The assertions take for granted that the channels settle to each new level for at least one clock. Under that condition the synchronised state walks through single-bit or double-bit changes only, and the counter properties depend on that. The stimulus holds every encoder level for one or more whole cycles and changes it only at the falling clock edge. It makes random moves, skips included, with hold times long enough that no detent is dropped. It then adds directed bursts of one-cycle steps that fill the waiting slots on purpose, so that both the drop rule and the service order are tested.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef logic [1:0] enc_state_t;

    localparam enc_state_t ST_REST = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2
    } pulse_phase_t;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    // +1 for a forward step, -1 for a backward step, 0 otherwise
    function automatic logic signed [1:0] step_of(enc_state_t prv, enc_state_t cur);
        logic signed [1:0] s;
        s = 2'sd0;
        unique case ({prv, cur})
            4'b11_01, 4'b01_00, 4'b00_10, 4'b10_11: s = 2'sd1;
            4'b11_10, 4'b10_00, 4'b00_01, 4'b01_11: s = -2'sd1;
            default:                                 s = 2'sd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '1;
                    else     stage_q[g] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '1;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/qpc_step_tracker.sv
module qpc_step_tracker
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  enc_state_t cur,
    output logic       up_evt,
    output logic       down_evt
);
    enc_state_t        prev_q;
    logic signed [2:0] cnt_q;
    logic signed [3:0] sum;
    logic signed [2:0] cnt_d;
    logic signed [1:0] stp;

    always_comb begin
        stp      = (cur != prev_q) ? step_of(prev_q, cur) : 2'sd0;
        sum      = 4'(cnt_q) + 4'(stp);
        up_evt   = (sum > 4'sd3);
        down_evt = (sum < -4'sd3);
        if (up_evt)        cnt_d = 3'(sum - 4'sd4);
        else if (down_evt) cnt_d = 3'(sum + 4'sd4);
        else               cnt_d = 3'(sum);
        if (cur == ST_REST) cnt_d = 3'sd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= ST_REST;
            cnt_q  <= 3'sd0;
        end else begin
            prev_q <= cur;
            cnt_q  <= cnt_d;
        end
    end

    // R6: resting state leaves a zero count
    a_r6_rest_clears: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_REST) |=> (cnt_q == 3'sd0));

    // R5: a double-bit jump away from rest does not move the count
    a_r5_skip_holds: assert property (@(posedge clk) disable iff (rst)
        (((cur ^ prev_q) == 2'b11) && (cur != ST_REST)) |=> $stable(cnt_q));

    // R4: the count never leaves the +/-3 window between clocks
    a_r4_count_window: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= -3'sd3) && (cnt_q <= 3'sd3));

    // R2/R3: never both directions from one transition
    a_r2_one_event: assert property (@(posedge clk) disable iff (rst)
        !(up_evt && down_evt));
endmodule

// File: rtl/qpc_pulse_sched.sv
module qpc_pulse_sched
    import qpc_pkg::*;
#(
    parameter int PULSE_CYC = 128,
    parameter int GAP_CYC   = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic up_evt,
    input  logic down_evt,
    output logic up_n,
    output logic down_n
);
    localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] P_LAST = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] G_LAST = TW'(GAP_CYC - 1);

    pulse_phase_t  phase_q, phase_d;
    dir_t          dir_q, dir_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          pend_up_q, pend_up_d;
    logic          pend_dn_q, pend_dn_d;
    logic          dn_older_q, dn_older_d;
    logic          used;

    always_comb begin
        phase_d    = phase_q;
        dir_d      = dir_q;
        tmr_d      = tmr_q;
        pend_up_d  = pend_up_q;
        pend_dn_d  = pend_dn_q;
        dn_older_d = dn_older_q;
        used       = 1'b0;

        unique case (phase_q)
            PH_IDLE: begin
                if (pend_up_q || pend_dn_q) begin
                    phase_d = PH_LOW;
                    tmr_d   = '0;
                    if (pend_dn_q && (!pend_up_q || dn_older_q)) begin
                        dir_d     = DIR_DOWN;
                        pend_dn_d = 1'b0;
                    end else begin
                        dir_d     = DIR_UP;
                        pend_up_d = 1'b0;
                    end
                end else if (up_evt || down_evt) begin
                    phase_d = PH_LOW;
                    tmr_d   = '0;
                    dir_d   = down_evt ? DIR_DOWN : DIR_UP;
                    used    = 1'b1;
                end
            end
            PH_LOW: begin
                if (tmr_q == P_LAST) begin
                    phase_d = PH_GAP;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            default: begin
                if (tmr_q == G_LAST) begin
                    phase_d = PH_IDLE;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
        endcase

        if (!used) begin
            if (up_evt && !pend_up_d) begin
                pend_up_d  = 1'b1;
                dn_older_d = pend_dn_d;
            end
            if (down_evt && !pend_dn_d) begin
                pend_dn_d  = 1'b1;
                dn_older_d = !pend_up_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            dir_q      <= DIR_UP;
            tmr_q      <= '0;
            pend_up_q  <= 1'b0;
            pend_dn_q  <= 1'b0;
            dn_older_q <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            dir_q      <= dir_d;
            tmr_q      <= tmr_d;
            pend_up_q  <= pend_up_d;
            pend_dn_q  <= pend_dn_d;
            dn_older_q <= dn_older_d;
        end
    end

    assign up_n   = !((phase_q == PH_LOW) && (dir_q == DIR_UP));
    assign down_n = !((phase_q == PH_LOW) && (dir_q == DIR_DOWN));

    // R9: the two lines are never low together
    a_r9_not_both_low: assert property (@(posedge clk) disable iff (rst)
        up_n || down_n);

    // R10: a waiting pulse is not lost while another is driven
    a_r10_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && pend_up_q) |=> pend_up_q);

    // R7: the low-phase timer stays inside the pulse width
    a_r7_low_bound: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |-> (tmr_q <= P_LAST));

    // R8: a pulse ends into the gap phase, never straight into a new pulse
    a_r8_gap_after: assert property (@(posedge clk) disable iff (rst)
        ($rose(up_n) || $rose(down_n)) |-> (phase_q == PH_GAP));
endmodule

// File: rtl/qenc_pulse_conv.sv
module qenc_pulse_conv
    import qpc_pkg::*;
#(
    parameter int PULSE_CYC   = 128,
    parameter int GAP_CYC     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    output logic inc_pulse_n,
    output logic dec_pulse_n
);
    enc_state_t st_sync;
    logic       up_evt, down_evt;

    qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({enc_b, enc_a}),
        .d_out (st_sync)
    );

    qpc_step_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .cur      (st_sync),
        .up_evt   (up_evt),
        .down_evt (down_evt)
    );

    qpc_pulse_sched #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .up_evt   (up_evt),
        .down_evt (down_evt),
        .up_n     (inc_pulse_n),
        .down_n   (dec_pulse_n)
    );
endmodule

// File: tb/qenc_pulse_conv_tb_top.sv
module qenc_pulse_conv_tb_top;
    localparam int P = 16;
    localparam int G = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_a = 1'b1, enc_b = 1'b1;
    logic inc_pulse_n, dec_pulse_n;

    always #2.5 clk = ~clk;

    qenc_pulse_conv #(.PULSE_CYC(P), .GAP_CYC(G)) dut_i (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .inc_pulse_n(inc_pulse_n), .dec_pulse_n(dec_pulse_n)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    // observed pulse log: 0 = inc, 1 = dec
    int obs [512];
    int n_obs = 0;
    int exp_q [512];
    int n_exp = 0;
    int last_rise = -1000;
    int low_start = 0;
    logic pi = 1'b1, pd = 1'b1;
    int w_fail = 0, w_chk = 0, g_fail = 0, both_fail = 0;

    // model state
    logic [1:0] m_prev = 2'b11;
    int m_cnt = 0;

    function automatic int step_m(logic [1:0] p, logic [1:0] c);
        if ((p == 2'b11 && c == 2'b01) || (p == 2'b01 && c == 2'b00) ||
            (p == 2'b00 && c == 2'b10) || (p == 2'b10 && c == 2'b11)) return 1;
        if ((p == 2'b11 && c == 2'b10) || (p == 2'b10 && c == 2'b00) ||
            (p == 2'b00 && c == 2'b01) || (p == 2'b01 && c == 2'b11)) return -1;
        return 0;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (!inc_pulse_n && !dec_pulse_n) both_fail <= both_fail + 1;
            if ((pi && !inc_pulse_n) || (pd && !dec_pulse_n)) begin
                if (cyc - last_rise < G + 1) begin
                    g_fail <= g_fail + 1;
                    $display("FAIL R8 actual=%0d expected>=%0d", cyc - last_rise - 1, G);
                end
                low_start <= cyc;
                if (n_obs < 512) begin
                    obs[n_obs] <= (!inc_pulse_n) ? 0 : 1;
                    n_obs <= n_obs + 1;
                end
            end
            if ((!pi && inc_pulse_n) || (!pd && dec_pulse_n)) begin
                w_chk <= w_chk + 1;
                last_rise <= cyc;
                if (cyc - low_start != P) begin
                    w_fail <= w_fail + 1;
                    $display("FAIL R7 actual=%0d expected=%0d", cyc - low_start, P);
                end
            end
        end
        pi <= inc_pulse_n;
        pd <= dec_pulse_n;
    end

    task automatic drive(logic [1:0] s, int hold);
        @(negedge clk);
        {enc_b, enc_a} = s;
        repeat (hold - 1) @(negedge clk);
    endtask

    // model-tracked move (used only when no detent can be dropped)
    task automatic mv(logic [1:0] s, int hold);
        int st;
        st = (s != m_prev) ? step_m(m_prev, s) : 0;
        m_cnt += st;
        if (m_cnt > 3) begin m_cnt -= 4; exp_q[n_exp] = 0; n_exp++; end
        if (m_cnt < -3) begin m_cnt += 4; exp_q[n_exp] = 1; n_exp++; end
        if (s == 2'b11) m_cnt = 0;
        m_prev = s;
        drive(s, hold);
    endtask

    task automatic push_exp(int d);
        exp_q[n_exp] = d;
        n_exp++;
    endtask

    task automatic phase_check(string req);
        repeat (4 * (P + G) + 10) @(negedge clk);
        check(n_obs == n_exp, {req, " count"}, n_obs, n_exp);
        for (int i = 0; i < n_exp && i < n_obs; i++)
            check(obs[i] == exp_q[i], {req, " order"}, obs[i], exp_q[i]);
        n_obs = 0;
        n_exp = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240611);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(inc_pulse_n == 1'b1, "R1 inc idle", inc_pulse_n, 1);
        check(dec_pulse_n == 1'b1, "R1 dec idle", dec_pulse_n, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R2: one forward detent from rest
        mv(2'b01, 3); mv(2'b00, 3); mv(2'b10, 3); mv(2'b11, 3);
        phase_check("R2");
        // R3: one backward detent
        mv(2'b10, 3); mv(2'b00, 3); mv(2'b01, 3); mv(2'b11, 3);
        phase_check("R3");
        // R4: partial detent turned back
        mv(2'b01, 3); mv(2'b00, 3); mv(2'b01, 3); mv(2'b11, 3);
        phase_check("R4");
        // R5: skip 2->1 leaves count, 1->0 then completes forward
        mv(2'b01, 3); mv(2'b00, 3); mv(2'b10, 3); mv(2'b01, 3);
        mv(2'b00, 3); mv(2'b01, 3); mv(2'b11, 3);
        phase_check("R5");
        // R6: leftover count cleared by a skip to rest
        mv(2'b01, 3); mv(2'b00, 3); mv(2'b11, 3);
        mv(2'b10, 3); mv(2'b00, 3); mv(2'b01, 3); mv(2'b11, 3);
        phase_check("R6");

        // R10: three fast forward detents -> active + one waiting
        drive(2'b01, 1); drive(2'b00, 1); drive(2'b10, 1); drive(2'b11, 1);
        drive(2'b01, 1); drive(2'b00, 1); drive(2'b10, 1); drive(2'b11, 1);
        drive(2'b01, 1); drive(2'b00, 1); drive(2'b10, 1); drive(2'b11, 1);
        push_exp(0); push_exp(0);
        phase_check("R10");

        // R11: fwd, back, fwd fast -> inc, then dec (queued first), then inc
        drive(2'b01, 1); drive(2'b00, 1); drive(2'b10, 1); drive(2'b11, 1);
        drive(2'b10, 1); drive(2'b00, 1); drive(2'b01, 1); drive(2'b11, 1);
        drive(2'b01, 1); drive(2'b00, 1); drive(2'b10, 1); drive(2'b11, 1);
        push_exp(0); push_exp(1); push_exp(0);
        phase_check("R11");

        // random walk, skips included, slow enough that nothing is dropped
        m_prev = 2'b11;
        m_cnt  = 0;
        for (int k = 0; k < 600; k++) begin
            logic [1:0] nx;
            nx = m_prev ^ 2'(1 + ($urandom % 3));
            mv(nx, 10 + ($urandom % 5));
        end
        mv(2'b11, 10);
        phase_check("R2 R3 random");

        check(w_fail == 0, "R7 widths", w_fail, 0);
        check(w_chk > 0, "R7 pulses seen", w_chk, 1);
        check(g_fail == 0, "R8 gaps", g_fail, 0);
        check(both_fail == 0, "R9 overlap", both_fail, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule